// File: doc/BRIEF.md
# Trellis Survivor Traceback and Bit Packer

This block reconstructs the decoded data of a 16-state, rate-one-half trellis once the forward metric pass has stored one decision word per stage. Given a frame length in stages, it reads the decision memory from the last stage back to the first, following the survivor path from state zero, which the encoder's tail bits force at the frame end. Each step selects one decision bit from the current word and uses it to rebuild the preceding state. The most significant bit of each state visited is the data bit of that stage.

Because the walk runs backward, the data bits come out newest first. The block gathers them into 16-bit words, reverses each word so that earlier stages sit in higher bit positions, and emits each word with its index. Words appear highest index first, so a consumer can write them straight into a frame buffer. A done flag marks the end of the frame.

Top module: `vt_traceback`

## Requirements
- R1: After reset, `rd_en`, `out_valid` and `done` are all 0.
- R2: After an accepted `start` with `num_stages` = N > 0, the block asserts `rd_en` on N consecutive cycles, with `rd_addr` stepping N-1, N-2, ... down to 0. The memory returns `rd_data` one cycle after the address is presented.
- R3: The walk begins in state 0. For current state s (4 bits), the decision bit is the word bit at position p = (2·s + s[3]) mod 16, where position 0 is the word MSB, so the bit read is `rd_data[15-p]`.
- R4: The data bit for the stage being read is s[3] of the current state. The next state is ((s << 1) | decision) & 15.
- R5: Word w of the output carries the data bit of stage t (16·w ≤ t < 16·w+16) in bit 15 - (t mod 16), so stage 16·w lands in the MSB.
- R6: When N is not a multiple of 16, the last word (highest index) holds its stages in its upper bits and zeros in all unused low-order bits.
- R7: Each word is presented for exactly one cycle with `out_valid`. Words appear in descending index order, `out_idx` gives the word number, and no other words appear.
- R8: `done` goes to 1 in the same cycle as the word with index 0. It stays 1 until the next accepted `start`, which clears it.
- R9: A `start` with N = 0 issues no reads and no words, and sets `done` one cycle later.
- R10: A `start` that arrives while reads or processing are still in flight is ignored: the running frame's addresses and words are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| num_stages | input | STAGE_W | Frame length in trellis stages |
| rd_en | output | 1 | Decision memory read strobe |
| rd_addr | output | STAGE_W | Stage index of the word being read |
| rd_data | input | 2^STATE_BITS | Decision word, one cycle after the address |
| out_word | output | PACK_W | Packed decoded bits, forward order |
| out_idx | output | STAGE_W-log2(PACK_W) | Index of the packed word |
| out_valid | output | 1 | `out_word`/`out_idx` valid this cycle |
| done | output | 1 | Frame traceback complete |

## Verification
The hardest check is confirming that the block follows a real survivor path rather than merely reproducing a self-consistent walk. Random decision words only test agreement with a reference model. To close that gap, the stimulus encodes a known data sequence with a four-zero tail, tracks the encoder states forward, and plants in each stage's word the one decision bit that points back to the true predecessor. The expected output is then the original data itself. Frame lengths of 0, 1, 17 and 40 cover partial final words. A second start, issued in the middle of a frame, exercises the ignore rule.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int unsigned VT_STATE_BITS = 4;
  localparam int unsigned VT_PACK_W     = 16;
  localparam int unsigned VT_STAGE_W    = 10;

  function automatic int unsigned vt_idx_w(int unsigned stage_w, int unsigned pack_w);
    return stage_w - $clog2(pack_w);
  endfunction
endpackage

// File: rtl/vt_stage_reader.sv
module vt_stage_reader #(
  parameter int unsigned STAGE_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_ok,
  input  logic [STAGE_W-1:0] num_stages,
  output logic               rd_en,
  output logic [STAGE_W-1:0] rd_addr,
  output logic               tag_vld,
  output logic [STAGE_W-1:0] tag_stage
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      tag_vld   <= 1'b0;
      tag_stage <= '0;
    end else begin
      tag_vld   <= rd_en;
      tag_stage <= rd_addr;
      if (start_ok && num_stages != '0) begin
        rd_en   <= 1'b1;
        rd_addr <= num_stages - 1'b1;
      end else if (rd_en) begin
        if (rd_addr == '0) rd_en <= 1'b0;
        else               rd_addr <= rd_addr - 1'b1;
      end
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != '0) |=> (rd_en && rd_addr == $past(rd_addr) - 1'b1));

  // R2
  addr_last_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == '0 && !start_ok) |=> !rd_en);
endmodule

// File: rtl/vt_state_walk.sv
module vt_state_walk #(
  parameter int unsigned STATE_BITS = 4,
  localparam int unsigned WORD_W    = 1 << STATE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              step,
  input  logic [WORD_W-1:0] dword,
  output logic              dec_bit
);
  logic [STATE_BITS-1:0] state;
  logic [STATE_BITS-1:0] pos;
  logic                  sel;

  // (2*s + msb) mod 2^SB is a left rotation of the state
  always_comb begin
    pos     = {state[STATE_BITS-2:0], state[STATE_BITS-1]};
    sel     = dword[~pos];
    dec_bit = state[STATE_BITS-1];
  end

  always_ff @(posedge clk) begin
    if (rst || restart) state <= '0;
    else if (step)      state <= {state[STATE_BITS-2:0], sel};
  end

  // R3
  walk_origin_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> state == '0);

  // R4
  walk_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !restart) |=> state[STATE_BITS-1:1] == $past(state[STATE_BITS-2:0]));
endmodule

// File: rtl/vt_packer.sv
module vt_packer #(
  parameter int unsigned PACK_W  = 16,
  parameter int unsigned STAGE_W = 10,
  localparam int unsigned LOG_P  = $clog2(PACK_W),
  localparam int unsigned IDX_W  = STAGE_W - LOG_P
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic               in_bit,
  input  logic [STAGE_W-1:0] in_stage,
  output logic [PACK_W-1:0]  out_word,
  output logic [IDX_W-1:0]   out_idx,
  output logic               out_valid
);
  logic [PACK_W-1:0] sh;
  logic [PACK_W-1:0] sh_next;
  logic [PACK_W-1:0] rev_w;

  assign sh_next = {sh[PACK_W-2:0], in_bit};

  for (genvar g = 0; g < PACK_W; g++) begin : g_rev
    assign rev_w[g] = sh_next[PACK_W-1-g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      out_word  <= '0;
      out_idx   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (in_vld) begin
        if (in_stage[LOG_P-1:0] == '0) begin
          out_word  <= rev_w;
          out_idx   <= in_stage[STAGE_W-1:LOG_P];
          out_valid <= 1'b1;
          sh        <= '0;
        end else begin
          sh <= sh_next;
        end
      end
    end
  end

  // R7
  word_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6
  word_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_stage[LOG_P-1:0] == '0) |=> (out_valid && out_idx == $past(in_stage[STAGE_W-1:LOG_P])));
endmodule

// File: rtl/vt_traceback.sv
module vt_traceback
  import vt_pkg::*;
#(
  parameter int unsigned STATE_BITS = VT_STATE_BITS,
  parameter int unsigned PACK_W     = VT_PACK_W,
  parameter int unsigned STAGE_W    = VT_STAGE_W
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic [STAGE_W-1:0]                  num_stages,
  output logic                                rd_en,
  output logic [STAGE_W-1:0]                  rd_addr,
  input  logic [(1<<STATE_BITS)-1:0]          rd_data,
  output logic [PACK_W-1:0]                   out_word,
  output logic [STAGE_W-$clog2(PACK_W)-1:0]   out_idx,
  output logic                                out_valid,
  output logic                                done
);
  localparam int unsigned IDX_W = vt_idx_w(STAGE_W, PACK_W);

  logic               tag_vld;
  logic [STAGE_W-1:0] tag_stage;
  logic               busy;
  logic               start_ok;
  logic               dec_bit;

  assign busy     = rd_en | tag_vld;
  assign start_ok = start & ~busy;

  vt_stage_reader #(.STAGE_W(STAGE_W)) u_reader (
    .clk(clk), .rst(rst), .start_ok(start_ok), .num_stages(num_stages),
    .rd_en(rd_en), .rd_addr(rd_addr), .tag_vld(tag_vld), .tag_stage(tag_stage)
  );

  vt_state_walk #(.STATE_BITS(STATE_BITS)) u_walk (
    .clk(clk), .rst(rst), .restart(start_ok), .step(tag_vld),
    .dword(rd_data), .dec_bit(dec_bit)
  );

  vt_packer #(.PACK_W(PACK_W), .STAGE_W(STAGE_W)) u_pack (
    .clk(clk), .rst(rst), .in_vld(tag_vld), .in_bit(dec_bit), .in_stage(tag_stage),
    .out_word(out_word), .out_idx(out_idx), .out_valid(out_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)                              done <= 1'b0;
    else if (start_ok)                    done <= (num_stages == '0);
    else if (tag_vld && tag_stage == '0)  done <= 1'b1;
  end

  // R8
  done_with_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ((out_valid && out_idx == IDX_W'(0)) || $past(start_ok && num_stages == '0)));

  // R9
  empty_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (start_ok && num_stages == '0) |=> (!rd_en && done));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (start && rd_en && rd_addr != '0) |=> (rd_en && rd_addr == $past(rd_addr) - 1'b1));
endmodule

// File: tb/vt_traceback_tb.sv
`timescale 1ns/1ps
module vt_traceback_tb;
  localparam int STAGE_W = 10;
  localparam int DEPTH   = 1 << STAGE_W;
  localparam int IDX_W   = STAGE_W - 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic [STAGE_W-1:0] num_stages = '0;
  logic               rd_en;
  logic [STAGE_W-1:0] rd_addr;
  logic [15:0]        rd_data = '0;
  logic [15:0]        out_word;
  logic [IDX_W-1:0]   out_idx;
  logic               out_valid;
  logic               done;

  always #2.5 clk = ~clk;

  vt_traceback u_dut (
    .clk(clk), .rst(rst), .start(start), .num_stages(num_stages),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_word(out_word), .out_idx(out_idx), .out_valid(out_valid), .done(done)
  );

  logic [15:0] mem [DEPTH];
  bit          dec_a [DEPTH];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] q_word [$];
  int          q_idx  [$];
  int exp_addr   = 0;
  int reads_seen = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pos_of(input int s);
    return ((2 * s) + ((s >> 3) & 1)) % 16;
  endfunction

  // monitor: scoreboard pop and address tracking
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_word.size() == 0) begin
        check(1'b0, "R7 unexpected word", longint'(out_idx), -1);
      end else begin
        logic [15:0] ew;
        int ei;
        ew = q_word.pop_front();
        ei = q_idx.pop_front();
        check(out_idx == IDX_W'(ei), "R7 word index", out_idx, ei);
        check(out_word == ew, "R5/R6 word value", out_word, ew);
        if (ei == 0) check(done == 1'b1, "R8 done with word 0", done, 1);
      end
    end
    if (!rst && rd_en) begin
      check(int'(rd_addr) == exp_addr, "R2 read address", rd_addr, exp_addr);
      exp_addr--;
      reads_seen++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  // driver: build memory, push expected words, start and wait
  task automatic run_frame(input int n, input bit path, input int poke);
    logic [3:0] s;
    logic [3:0] sn;
    if (path) begin
      s = '0;
      for (int t = 0; t < n; t++) begin
        bit u;
        logic [15:0] w;
        u  = (t >= n - 4) ? 1'b0 : 1'($urandom % 2);
        sn = {u, s[3:1]};
        w  = 16'($urandom);
        w[15 - pos_of(int'(sn))] = s[0];
        mem[t]   = w;
        dec_a[t] = u;
        s = sn;
      end
    end else begin
      for (int t = 0; t < n; t++) mem[t] = 16'($urandom);
      s = '0;
      for (int t = n - 1; t >= 0; t--) begin
        dec_a[t] = s[3];
        s = {s[2:0], mem[t][15 - pos_of(int'(s))]};
      end
    end
    if (n > 0) begin
      for (int w = (n - 1) / 16; w >= 0; w--) begin
        logic [15:0] word;
        word = '0;
        for (int t = 16 * w; t < n && t < 16 * w + 16; t++) word[15 - (t % 16)] = dec_a[t];
        q_word.push_back(word);
        q_idx.push_back(w);
      end
    end
    exp_addr   = n - 1;
    reads_seen = 0;
    @(negedge clk);
    start = 1'b1;
    num_stages = STAGE_W'(n);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2 * n + 20 && !done; k++) begin
      if (poke != 0 && k == poke) begin
        start = 1'b1;
        num_stages = STAGE_W'(5);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R8 done held", done, 1);
    check(q_word.size() == 0, "R7 all words seen", q_word.size(), 0);
    check(reads_seen == n, "R2/R10 read count", reads_seen, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(rd_en == 1'b0, "R1 rd_en after reset", rd_en, 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);

    // R3 R4 R5 R6: planted survivor path, partial last word
    run_frame(40, 1'b1, 0);
    // R3 R4 R5: random decisions, whole words
    run_frame(32, 1'b0, 0);
    // R6: single stage
    run_frame(1, 1'b0, 0);
    // R6: one bit over a word boundary, planted path
    run_frame(17, 1'b1, 0);
    // R9: empty frame
    run_frame(0, 1'b0, 0);
    check(out_valid == 1'b0, "R9 no word", out_valid, 0);
    // R10: second start mid-frame is ignored
    run_frame(20, 1'b0, 6);
    // R8: done cleared by the next accepted start
    @(negedge clk);
    start = 1'b1;
    num_stages = STAGE_W'(3);
    mem[0] = 16'h0; mem[1] = 16'h0; mem[2] = 16'h0;
    q_word.push_back(16'h0);
    q_idx.push_back(0);
    exp_addr = 2;
    reads_seen = 0;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R8 done cleared by start", done, 0);
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R8 done after short frame", done, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule